// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may place the link into low-power idle (LPI) and when it must leave it. Software programs an enable bit, an automatic mode bit, the PHY link-good bit, a link-stable time in milliseconds and a wake time in microseconds. The line side reports whether a frame waits for transmission and whether the far end is sending LPI on the receive path. The block drives `tx_lpi` to request LPI signalling and `tx_hold` to keep the transmitter quiet both during LPI and while the link wakes up again.

A free-running prescaler turns the core clock into microsecond and millisecond ticks. After the link comes up, entry stays blocked until the link-stable time has elapsed. After LPI signalling stops, transmission stays held for the wake time. Entry and exit on both transmit and receive sides set four sticky flags, which a read strobe clears. Any set flag raises an interrupt unless it is masked.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After synchronous reset, `tx_lpi`, `tx_hold`, `lpi_flags` and `lpi_irq` are all 0.
- R2: After `cfg_link_up` rises, `tx_lpi` does not assert before `cfg_ls_ms` milliseconds (`cfg_ls_ms`*US_PER_MS*CLK_PER_US clocks) and, once every other entry condition holds, asserts within one more millisecond plus a few clocks.
- R3: With `cfg_auto`=1, `tx_lpi` asserts when `cfg_lpi_en`, `cfg_link_up` and the expired link-stable time all hold and `tx_pending` is 0.
- R4: With `cfg_auto`=1, `tx_pending`=1 during LPI deasserts `tx_lpi` on the next clock, and while `tx_pending` stays 1 LPI is not entered again.
- R5: With `cfg_auto`=0, LPI is entered and kept while `cfg_lpi_en`, link and the link-stable time hold, whatever `tx_pending` is; clearing `cfg_lpi_en` exits LPI.
- R6: Dropping `cfg_link_up` during LPI deasserts `tx_lpi` on the next clock and restarts the link-stable time, so re-entry again waits the full `cfg_ls_ms`.
- R7: `tx_hold` is 1 whenever `tx_lpi` is 1, and after `tx_lpi` falls it stays 1 for at least `cfg_tw_us` microseconds and at most one microsecond plus a few clocks longer.
- R8: Flag bit 0 is set by a rise of `tx_lpi`, bit 1 by its fall, bit 2 by a rise of `rx_lpi` and bit 3 by its fall; a set bit stays set.
- R9: A one-clock `flag_rd` pulse clears all flags on the next clock, except a flag whose event occurs in that same clock, which ends set.
- R10: `lpi_irq` follows (any flag set and `irq_mask`=0) with one clock of delay; with `irq_mask`=1 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lpi_en | input | 1 | LPI enable |
| cfg_auto | input | 1 | Automatic entry/exit driven by pending frames |
| cfg_link_up | input | 1 | PHY link-good status |
| cfg_ls_ms | input | LS_W | Link-stable time in milliseconds |
| cfg_tw_us | input | TW_W | Wake time in microseconds |
| tx_pending | input | 1 | A frame waits for transmission |
| rx_lpi | input | 1 | Receive path is in LPI (synchronous) |
| flag_rd | input | 1 | Status read strobe, clears flags |
| irq_mask | input | 1 | Masks the LPI interrupt |
| tx_lpi | output | 1 | Request LPI signalling on transmit |
| tx_hold | output | 1 | Transmitter must not send |
| lpi_flags | output | 4 | Sticky transition flags (bit map in R8) |
| lpi_irq | output | 1 | LPI interrupt |

## Verification
Entry is tried after a fresh link-up, where the measured delay separates a correct link-stable gate from a missing or short one, and again after a link drop, which shows whether the timer really restarts. Exit is provoked three ways, by a pending frame in automatic mode, by a link drop and by clearing enable in manual mode; each exit also times the wake hold against its lower and upper bounds. Manual mode with a pending frame tells the two modes apart, and a read strobe landing in the same clock as a receive-side event tells a set-wins flag from a clear-wins one.

// File: rtl/eee_pkg.sv
package eee_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2
  } lpi_state_t;

  localparam int NUM_FLAGS   = 4;
  localparam int FLG_TX_IN   = 0;
  localparam int FLG_TX_OUT  = 1;
  localparam int FLG_RX_IN   = 2;
  localparam int FLG_RX_OUT  = 3;
endpackage

// File: rtl/eee_tick_gen.sv
module eee_tick_gen #(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic us_tick,
  output logic ms_tick
);
  localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int MW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic [UW-1:0] us_cnt;
  logic [MW-1:0] ms_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      us_cnt  <= '0;
      ms_cnt  <= '0;
      us_tick <= 1'b0;
      ms_tick <= 1'b0;
    end else begin
      us_tick <= 1'b0;
      ms_tick <= 1'b0;
      if (us_cnt == UW'(CLK_PER_US - 1)) begin
        us_cnt  <= '0;
        us_tick <= 1'b1;
      end else begin
        us_cnt <= us_cnt + 1'b1;
      end
      if (us_tick) begin
        if (ms_cnt == MW'(US_PER_MS - 1)) begin
          ms_cnt  <= '0;
          ms_tick <= 1'b1;
        end else begin
          ms_cnt <= ms_cnt + 1'b1;
        end
      end
    end
  end

  AST_MS_AFTER_US: assert property (@(posedge clk) disable iff (rst)
    ms_tick |-> $past(us_tick)); // R2
endmodule

// File: rtl/eee_ls_timer.sv
module eee_ls_timer #(
  parameter int LS_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            link_up,
  input  logic            ms_tick,
  input  logic [LS_W-1:0] ls_ms,
  output logic            ls_ok
);
  logic [LS_W:0] ls_cnt;

  assign ls_ok = ls_cnt > {1'b0, ls_ms};

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      ls_cnt <= '0;
    end else if (ms_tick && !ls_ok) begin
      ls_cnt <= ls_cnt + 1'b1;
    end
  end

  AST_LS_RESTART: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> !ls_ok); // R6
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_pkg::*;
#(
  parameter int TW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            us_tick,
  input  logic            ls_ok,
  input  logic            cfg_lpi_en,
  input  logic            cfg_auto,
  input  logic            cfg_link_up,
  input  logic [TW_W-1:0] cfg_tw_us,
  input  logic            tx_pending,
  output logic            tx_lpi,
  output logic            tx_hold
);
  lpi_state_t    state, state_nxt;
  logic [TW_W:0] tw_cnt;
  logic          tw_done;

  assign tw_done = tw_cnt > {1'b0, cfg_tw_us};

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_ACTIVE:
        if (cfg_lpi_en && cfg_link_up && ls_ok && (!cfg_auto || !tx_pending))
          state_nxt = ST_SLEEP;
      ST_SLEEP:
        if (!cfg_lpi_en || !cfg_link_up || (cfg_auto && tx_pending))
          state_nxt = ST_WAKE;
      ST_WAKE:
        if (tw_done)
          state_nxt = ST_ACTIVE;
      default:
        state_nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ACTIVE;
      tw_cnt  <= '0;
      tx_lpi  <= 1'b0;
      tx_hold <= 1'b0;
    end else begin
      state   <= state_nxt;
      tx_lpi  <= (state_nxt == ST_SLEEP);
      tx_hold <= (state_nxt != ST_ACTIVE);
      if (state != ST_WAKE)
        tw_cnt <= '0;
      else if (us_tick && !tw_done)
        tw_cnt <= tw_cnt + 1'b1;
    end
  end

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_lpi) |-> $past(ls_ok)); // R2
  AST_PENDING_WAKES: assert property (@(posedge clk) disable iff (rst)
    (tx_lpi && cfg_auto && tx_pending) |=> !tx_lpi); // R4
  AST_LINK_DROP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (tx_lpi && !cfg_link_up) |=> !tx_lpi); // R6
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_hold) |-> $past(tw_cnt > {1'b0, cfg_tw_us})); // R7
endmodule

// File: rtl/eee_lpi_flags.sv
module eee_lpi_flags
  import eee_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_lpi,
  input  logic                 rx_lpi,
  input  logic                 flag_rd,
  input  logic                 irq_mask,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic                 tx_prev, rx_prev;
  logic [NUM_FLAGS-1:0] evt;

  assign evt[FLG_TX_IN]  =  tx_lpi && !tx_prev;
  assign evt[FLG_TX_OUT] = !tx_lpi &&  tx_prev;
  assign evt[FLG_RX_IN]  =  rx_lpi && !rx_prev;
  assign evt[FLG_RX_OUT] = !rx_lpi &&  rx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev <= 1'b0;
      rx_prev <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tx_prev <= tx_lpi;
      rx_prev <= rx_lpi;
      irq     <= (|flags) && !irq_mask;
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else
        flags[i] <= evt[i] || (flags[i] && !flag_rd);
    end
  end

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R8
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && evt == '0) |=> (flags == '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq); // R10
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int LS_W       = 11,
  parameter int TW_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_lpi_en,
  input  logic                 cfg_auto,
  input  logic                 cfg_link_up,
  input  logic [LS_W-1:0]      cfg_ls_ms,
  input  logic [TW_W-1:0]      cfg_tw_us,
  input  logic                 tx_pending,
  input  logic                 rx_lpi,
  input  logic                 flag_rd,
  input  logic                 irq_mask,
  output logic                 tx_lpi,
  output logic                 tx_hold,
  output logic [NUM_FLAGS-1:0] lpi_flags,
  output logic                 lpi_irq
);
  logic us_tick, ms_tick, ls_ok;

  eee_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick));

  eee_ls_timer #(.LS_W(LS_W)) u_ls (
    .clk(clk), .rst(rst), .link_up(cfg_link_up), .ms_tick(ms_tick),
    .ls_ms(cfg_ls_ms), .ls_ok(ls_ok));

  eee_lpi_fsm #(.TW_W(TW_W)) u_fsm (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ls_ok(ls_ok),
    .cfg_lpi_en(cfg_lpi_en), .cfg_auto(cfg_auto), .cfg_link_up(cfg_link_up),
    .cfg_tw_us(cfg_tw_us), .tx_pending(tx_pending),
    .tx_lpi(tx_lpi), .tx_hold(tx_hold));

  eee_lpi_flags u_flags (
    .clk(clk), .rst(rst), .tx_lpi(tx_lpi), .rx_lpi(rx_lpi),
    .flag_rd(flag_rd), .irq_mask(irq_mask), .flags(lpi_flags), .irq(lpi_irq));
endmodule

// File: tb/tb_eee_lpi_ctrl.sv
module tb_eee_lpi_ctrl;
  localparam int P   = 4;
  localparam int M   = 8;
  localparam int CPM = P * M;
  localparam int LS  = 3;
  localparam int TW  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_lpi_en = 1'b0, cfg_auto = 1'b0, cfg_link_up = 1'b0;
  logic [10:0] cfg_ls_ms = 11'd0;
  logic [15:0] cfg_tw_us = 16'd0;
  logic        tx_pending = 1'b0, rx_lpi = 1'b0, flag_rd = 1'b0, irq_mask = 1'b0;
  logic        tx_lpi, tx_hold, lpi_irq;
  logic [3:0]  lpi_flags;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int t_link = 0, t_fall = 0;
  bit ls_chk = 0, hold_chk = 0, done = 0;
  bit prev_lpi = 0, prev_hold = 0;
  bit exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  eee_lpi_ctrl #(.CLK_PER_US(P), .US_PER_MS(M)) dut (
    .clk(clk), .rst(rst), .cfg_lpi_en(cfg_lpi_en), .cfg_auto(cfg_auto),
    .cfg_link_up(cfg_link_up), .cfg_ls_ms(cfg_ls_ms), .cfg_tw_us(cfg_tw_us),
    .tx_pending(tx_pending), .rx_lpi(rx_lpi), .flag_rd(flag_rd),
    .irq_mask(irq_mask), .tx_lpi(tx_lpi), .tx_hold(tx_hold),
    .lpi_flags(lpi_flags), .lpi_irq(lpi_irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_edge(input bit v);
    exp_q.push_back(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected tx_lpi transitions and times the gates.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tx_lpi !== prev_lpi) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected tx_lpi edge", int'(tx_lpi), int'(prev_lpi));
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(tx_lpi == e, "R3 tx_lpi edge order", int'(tx_lpi), int'(e));
        end
        if (tx_lpi && ls_chk) begin
          ls_chk = 0;
          check((cyc - t_link) >= LS * CPM, "R2/R6 entry too early", cyc - t_link, LS * CPM);
          check((cyc - t_link) <= (LS + 1) * CPM + 4, "R2 entry too late", cyc - t_link, (LS + 1) * CPM + 4);
        end
        if (!tx_lpi) begin
          t_fall = cyc;
          hold_chk = 1;
        end
      end
      if (prev_hold && !tx_hold && hold_chk) begin
        hold_chk = 0;
        check((cyc - t_fall) >= TW * P, "R7 hold released early", cyc - t_fall, TW * P);
        check((cyc - t_fall) <= (TW + 1) * P + 3, "R7 hold released late", cyc - t_fall, (TW + 1) * P + 3);
      end
      if (tx_lpi && !tx_hold)
        check(1'b0, "R7 hold low during LPI", int'(tx_hold), 1);
      prev_lpi  = tx_lpi;
      prev_hold = tx_hold;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    check(tx_lpi == 0,    "R1 tx_lpi", int'(tx_lpi), 0);
    check(tx_hold == 0,   "R1 tx_hold", int'(tx_hold), 0);
    check(lpi_flags == 0, "R1 flags", int'(lpi_flags), 0);
    check(lpi_irq == 0,   "R1 irq", int'(lpi_irq), 0);

    // Automatic entry after link-stable time
    cfg_ls_ms = 11'(LS); cfg_tw_us = 16'(TW);
    cfg_lpi_en = 1; cfg_auto = 1;
    expect_edge(1); t_link = cyc; ls_chk = 1; cfg_link_up = 1;
    tick(160);
    check(tx_lpi == 1, "R3 automatic entry", int'(tx_lpi), 1);
    check(lpi_flags == 4'b0001, "R8 tx-enter flag", int'(lpi_flags), 1);
    check(lpi_irq == 1, "R10 irq on flag", int'(lpi_irq), 1);

    flag_rd = 1; tick(1); flag_rd = 0;
    check(lpi_flags == 0, "R9 clear on read", int'(lpi_flags), 0);
    tick(1);
    check(lpi_irq == 0, "R10 irq drops after clear", int'(lpi_irq), 0);

    // Pending frame wakes, and blocks re-entry
    expect_edge(0); tx_pending = 1;
    tick(2);
    check(tx_lpi == 0, "R4 pending exits LPI", int'(tx_lpi), 0);
    tick(60);
    check(tx_lpi == 0, "R4 no entry while pending", int'(tx_lpi), 0);
    check(tx_hold == 0, "R7 hold released after wake", int'(tx_hold), 0);
    check(lpi_flags == 4'b0010, "R8 tx-exit flag", int'(lpi_flags), 2);
    expect_edge(1); tx_pending = 0;
    tick(5);
    check(tx_lpi == 1, "R3 re-entry when idle", int'(tx_lpi), 1);

    // Link drop exits and restarts the link-stable time
    expect_edge(0); cfg_link_up = 0;
    tick(2);
    check(tx_lpi == 0, "R6 link drop exits", int'(tx_lpi), 0);
    tick(40);
    expect_edge(1); t_link = cyc; ls_chk = 1; cfg_link_up = 1;
    tick(160);
    check(tx_lpi == 1, "R6 re-entry after relink", int'(tx_lpi), 1);

    // Manual mode
    cfg_auto = 0; tx_pending = 1;
    tick(30);
    check(tx_lpi == 1, "R5 manual ignores pending", int'(tx_lpi), 1);
    expect_edge(0); cfg_lpi_en = 0;
    tick(2);
    check(tx_lpi == 0, "R5 clearing enable exits", int'(tx_lpi), 0);
    tick(40);
    check(tx_lpi == 0, "R5 stays out while disabled", int'(tx_lpi), 0);
    expect_edge(1); cfg_lpi_en = 1;
    tick(5);
    check(tx_lpi == 1, "R5 manual entry with pending", int'(tx_lpi), 1);
    expect_edge(0); cfg_lpi_en = 0; tx_pending = 0;
    tick(40);

    flag_rd = 1; tick(1); flag_rd = 0;
    tick(2);
    check(lpi_flags == 0, "R9 flags cleared", int'(lpi_flags), 0);

    // Receive side, mask
    rx_lpi = 1; tick(3);
    check(lpi_flags == 4'b0100, "R8 rx-enter flag", int'(lpi_flags), 4);
    rx_lpi = 0; tick(3);
    check(lpi_flags == 4'b1100, "R8 rx-exit flag", int'(lpi_flags), 12);
    irq_mask = 1; tick(2);
    check(lpi_irq == 0, "R10 masked irq", int'(lpi_irq), 0);
    irq_mask = 0; tick(2);
    check(lpi_irq == 1, "R10 unmasked irq", int'(lpi_irq), 1);

    // Read in the same clock as an event: event wins
    flag_rd = 1; rx_lpi = 1; tick(1); flag_rd = 0;
    check(lpi_flags == 4'b0100, "R9 same-clock event survives read", int'(lpi_flags), 4);
    tick(4);

    check(exp_q.size() == 0, "R3 all expected edges seen", exp_q.size(), 0);
    finish_run();
  end
endmodule